// File: doc/BRIEF.md
# Oversampling NRZI Clock Recovery

This block takes the hard-limited output of a tone demodulator, a single logic level, and turns it into data words for a downstream frame deframer. A shared base time strobe advances a small down-counter. Each time the counter expires, the input is sampled, which gives three samples per data bit at the nominal four-unit spacing. Every third sample is the decision sample. At a decision sample the block looks at where the most recent input transitions fell among the last three samples. If the transitions arrive late or early, it lengthens or shortens the next sample interval by one unit, which drags the sampling phase toward the centre of the bit.

Each decision sample is NRZI-decoded against the previous decision sample. The decoded bits are packed least-significant first into 16-bit words, and each word is delivered with a one-cycle valid pulse. A signed counter records the net number of late and early corrections so that software or a monitor can watch the drift of the loop.

Top module: `nrzi_clock_recovery`

## Requirements
- R1: After synchronous reset, `word_valid` is 0, `word_data` is 0, `corr_count` is 0, the previous-sample and previous-decision values are 0, and the transition history is clear.
- R2: The first sample is taken on the 4th `unit_tick` after reset. Without corrections, samples follow every 4 ticks. The sample phase counts 0,1,2, and phase 0 (including the very first sample) is the decision sample.
- R3: The decoded bit is 1 when the level at a decision sample equals the level at the previous decision sample, and 0 when it differs. The first decision is compared against 0.
- R4: Sixteen decoded bits form a word. The first bit decoded goes to `word_data[0]`. `word_valid` is high for exactly one clock, in the cycle after the tick that took the 16th decision sample.
- R5: A transition is counted at a sample whose level differs from the previous sample. At a decision sample with a transition there but none at the two samples before it (3-bit history 001, newest in bit 0), the next interval is 5 ticks and `corr_count` goes up by 1.
- R6: At a decision sample with a transition two samples earlier and none at the later two samples (history 100), the next interval is 3 ticks and `corr_count` goes down by 1.
- R7: Every other history at a decision sample, and every history at a non-decision sample, gives a 4-tick interval and leaves `corr_count` unchanged. This includes history 001 at a phase-1 sample and history 010 at a decision sample.
- R8: `word_data` changes only together with `word_valid`. `corr_count` changes only after a decision sample, and then by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | 1 | Hard-limited demodulator level |
| unit_tick | input | 1 | One-cycle base time unit strobe |
| word_valid | output | 1 | One-cycle strobe for a new word |
| word_data | output | 16 | Decoded word, earliest bit in bit 0 |
| corr_count | output | 16 | Signed net count of late minus early corrections |

## Verification
The checker assumes that `unit_tick` is a strobe that never stays high on two clocks in a row. It also assumes that `rx_level` is held steady except at clock edges, so each sample sees a defined level. Given those, words and corrections can only follow a tick, and two words are always at least three ticks apart. The stimulus issues every tick as a single high clock followed by a low clock. It changes the input level only on falling clock edges, just before a chosen tick, so each transition lands exactly at the sample it is aimed at. Transitions are placed before phase-2 samples for clean decoding, before decision samples to force a late correction, and before phase-1 samples to force an early one.

// File: rtl/nrzi_rec_pkg.sv
package nrzi_rec_pkg;
  typedef enum logic [1:0] {
    CORR_NONE  = 2'd0,
    CORR_LATE  = 2'd1,
    CORR_EARLY = 2'd2
  } corr_kind_e;
endpackage

// File: rtl/nrzi_tick_timer.sv
module nrzi_tick_timer #(
  parameter int PER_W      = 3,
  parameter int NOM_PERIOD = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             unit_tick,
  input  logic [PER_W-1:0] next_period,
  output logic             sample_stb
);
  localparam logic [PER_W-1:0] NOM  = PER_W'(NOM_PERIOD);
  localparam logic [PER_W-1:0] LAST = PER_W'(1);

  logic [PER_W-1:0] left_q;

  assign sample_stb = unit_tick && (left_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= NOM;
    end else if (unit_tick) begin
      if (left_q == LAST) left_q <= next_period;
      else                left_q <= left_q - LAST;
    end
  end
endmodule

// File: rtl/nrzi_phase_ctrl.sv
module nrzi_phase_ctrl
  import nrzi_rec_pkg::*;
#(
  parameter int SPB          = 3,
  parameter int HIST_W       = 3,
  parameter int PER_W        = 3,
  parameter int NOM_PERIOD   = 4,
  parameter int LATE_PERIOD  = 5,
  parameter int EARLY_PERIOD = 3,
  localparam int PH_W        = $clog2(SPB)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_stb,
  input  logic             rx_level,
  output logic [PER_W-1:0] next_period,
  output corr_kind_e       corr_kind,
  output logic             decide_stb,
  output logic [PH_W-1:0]  phase
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SPB - 1);

  logic              prev_q;
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_nxt;
  logic              is_dec;

  assign hist_nxt   = {hist_q[HIST_W-2:0], rx_level ^ prev_q};
  assign is_dec     = (phase == '0);
  assign decide_stb = sample_stb && is_dec;

  always_comb begin
    corr_kind = CORR_NONE;
    if (is_dec) begin
      case (hist_nxt[2:0])
        3'b001:  corr_kind = CORR_LATE;
        3'b100:  corr_kind = CORR_EARLY;
        default: corr_kind = CORR_NONE;
      endcase
    end
    case (corr_kind)
      CORR_LATE:  next_period = PER_W'(LATE_PERIOD);
      CORR_EARLY: next_period = PER_W'(EARLY_PERIOD);
      default:    next_period = PER_W'(NOM_PERIOD);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      hist_q <= '0;
      phase  <= '0;
    end else if (sample_stb) begin
      prev_q <= rx_level;
      hist_q <= hist_nxt;
      phase  <= (phase == PH_LAST) ? '0 : phase + PH_W'(1);
    end
  end
endmodule

// File: rtl/nrzi_word_packer.sv
module nrzi_word_packer #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              decide_stb,
  input  logic              rx_level,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);
  localparam logic [WORD_W:0] MARK = {1'b1, {WORD_W{1'b0}}};

  logic              last_dec_q;
  logic [WORD_W:0]   sr_q;
  logic [WORD_W:0]   sr_nxt;
  logic              bit_dec;

  assign bit_dec = ~(rx_level ^ last_dec_q);
  assign sr_nxt  = {bit_dec, sr_q[WORD_W:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      last_dec_q <= 1'b0;
      sr_q       <= MARK;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= 1'b0;
      if (decide_stb) begin
        last_dec_q <= rx_level;
        if (sr_nxt[0]) begin
          word_valid <= 1'b1;
          word_data  <= sr_nxt[WORD_W:1];
          sr_q       <= MARK;
        end else begin
          sr_q <= sr_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/nrzi_clock_recovery.sv
module nrzi_clock_recovery
  import nrzi_rec_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int CORR_W       = 16,
  parameter int SPB          = 3,
  parameter int HIST_W       = 3,
  parameter int NOM_PERIOD   = 4,
  parameter int LATE_PERIOD  = 5,
  parameter int EARLY_PERIOD = 3,
  localparam int PER_W       = $clog2(LATE_PERIOD + 1),
  localparam int PH_W        = $clog2(SPB)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rx_level,
  input  logic                     unit_tick,
  output logic                     word_valid,
  output logic [WORD_W-1:0]        word_data,
  output logic signed [CORR_W-1:0] corr_count
);
  logic             sample_stb;
  logic             decide_stb;
  logic [PER_W-1:0] next_period;
  logic [PH_W-1:0]  sample_phase;
  corr_kind_e       corr_kind;

  nrzi_tick_timer #(
    .PER_W(PER_W), .NOM_PERIOD(NOM_PERIOD)
  ) u_timer (
    .clk(clk), .rst(rst), .unit_tick(unit_tick),
    .next_period(next_period), .sample_stb(sample_stb)
  );

  nrzi_phase_ctrl #(
    .SPB(SPB), .HIST_W(HIST_W), .PER_W(PER_W), .NOM_PERIOD(NOM_PERIOD),
    .LATE_PERIOD(LATE_PERIOD), .EARLY_PERIOD(EARLY_PERIOD)
  ) u_phase (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .rx_level(rx_level),
    .next_period(next_period), .corr_kind(corr_kind),
    .decide_stb(decide_stb), .phase(sample_phase)
  );

  nrzi_word_packer #(
    .WORD_W(WORD_W)
  ) u_pack (
    .clk(clk), .rst(rst), .decide_stb(decide_stb), .rx_level(rx_level),
    .word_valid(word_valid), .word_data(word_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      corr_count <= '0;
    end else if (decide_stb) begin
      if (corr_kind == CORR_LATE)       corr_count <= corr_count + CORR_W'(1);
      else if (corr_kind == CORR_EARLY) corr_count <= corr_count - CORR_W'(1);
    end
  end
endmodule

// File: rtl/nrzi_clock_recovery_chk.sv
module nrzi_clock_recovery_chk #(
  parameter int WORD_W = 16,
  parameter int CORR_W = 16,
  parameter int PH_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              unit_tick,
  input logic              word_valid,
  input logic [WORD_W-1:0] word_data,
  input logic [CORR_W-1:0] corr_count,
  input logic [PH_W-1:0]   sample_phase
);
  // R4: a word strobe lasts one clock
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  // R4: a word only follows a tick taken at a decision sample
  a_r4_word_at_decision: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> ($past(unit_tick) && $past(sample_phase) == '0));

  // R8: word data is held between words
  a_r8_data_held: assert property (@(posedge clk) disable iff (rst)
    !$stable(word_data) |-> word_valid);

  // R8: the counter moves by one, only after a decision-sample tick
  a_r8_corr_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(corr_count) |->
      (((corr_count - $past(corr_count)) == CORR_W'(1)) ||
       ((corr_count - $past(corr_count)) == {CORR_W{1'b1}})));

  a_r8_corr_at_decision: assert property (@(posedge clk) disable iff (rst)
    !$stable(corr_count) |-> ($past(unit_tick) && $past(sample_phase) == '0));
endmodule

bind nrzi_clock_recovery nrzi_clock_recovery_chk #(
  .WORD_W(WORD_W), .CORR_W(CORR_W), .PH_W(PH_W)
) u_chk (
  .clk(clk), .rst(rst), .unit_tick(unit_tick), .word_valid(word_valid),
  .word_data(word_data), .corr_count(corr_count), .sample_phase(sample_phase)
);

// File: tb/tb_nrzi_clock_recovery.sv
module tb_nrzi_clock_recovery;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rx_level = 1'b0;
  logic              unit_tick = 1'b0;
  logic              word_valid;
  logic [15:0]       word_data;
  logic signed [15:0] corr_count;

  int n_checks = 0;
  int n_fails  = 0;
  int wcnt     = 0;
  logic [15:0] last_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nrzi_clock_recovery dut (
    .clk(clk), .rst(rst), .rx_level(rx_level), .unit_tick(unit_tick),
    .word_valid(word_valid), .word_data(word_data), .corr_count(corr_count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; rx_level = 1'b0; unit_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wcnt = 0;
    @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) unit_tick = 1'b1;
    @(negedge clk) unit_tick = 1'b0;
    if (word_valid) begin
      wcnt++;
      last_word = word_data;
    end
  endtask

  // one sample interval of per ticks, optional level flip just before the sample
  task automatic smp(input int per, input bit tog);
    for (int i = 0; i < per; i++) begin
      if (tog && i == per - 1) rx_level = ~rx_level;
      tick();
    end
  endtask

  task automatic test_reset();
    do_reset();
    check("R1 word_valid", int'(word_valid), 0);
    check("R1 word_data", int'(word_data), 0);
    check("R1 corr_count", int'(corr_count), 0);
  endtask

  task automatic test_constant();
    do_reset();
    for (int s = 0; s < 45; s++) smp(4, 1'b0);
    check("R2 no word before 16th decision", wcnt, 0);
    smp(4, 1'b0);
    check("R2 word at sample 45", wcnt, 1);
    check("R3 constant level word", int'(last_word), 16'hFFFF);
    check("R7 constant level no correction", int'(corr_count), 0);
  endtask

  // decision d at sample 3d; bit d is 0 by a flip before sample 3d-1
  task automatic test_pattern(input logic [31:0] want);
    do_reset();
    for (int s = 0; s < 94; s++) begin
      smp(4, (s % 3 == 2) && !want[(s + 1) / 3]);
      if (s == 44) check("R4 no early word", wcnt, 0);
      if (s == 45) begin
        check("R4 first word count", wcnt, 1);
        check("R3 first word bits", int'(last_word), int'(want[15:0]));
      end
    end
    check("R4 second word count", wcnt, 2);
    check("R3 second word bits", int'(last_word), int'(want[31:16]));
    check("R7 centred transitions no correction", int'(corr_count), 0);
  endtask

  task automatic test_late();
    do_reset();
    smp(4, 1'b0); smp(4, 1'b0); smp(4, 1'b0);
    smp(4, 1'b1);
    check("R5 first late correction", int'(corr_count), 1);
    smp(5, 1'b0); smp(4, 1'b0);
    smp(4, 1'b1);
    check("R5 second late correction", int'(corr_count), 2);
    smp(5, 1'b0);
    for (int s = 8; s < 45; s++) smp(4, 1'b0);
    check("R5 stretched interval no early word", wcnt, 0);
    smp(4, 1'b0);
    check("R5 word timing after stretch", wcnt, 1);
    check("R3 late scenario bits", int'(last_word), 16'hFFF9);
  endtask

  task automatic test_early();
    do_reset();
    smp(4, 1'b0);
    smp(4, 1'b1);
    smp(4, 1'b0);
    check("R7 history 001 at phase-1 sample", int'(corr_count), 0);
    smp(4, 1'b0);
    check("R6 early correction", int'(corr_count), -1);
    smp(3, 1'b0);
    for (int s = 5; s < 45; s++) smp(4, 1'b0);
    check("R6 shortened interval no early word", wcnt, 0);
    smp(4, 1'b0);
    check("R6 word timing after shrink", wcnt, 1);
    check("R3 early scenario bits", int'(last_word), 16'hFFFD);
  endtask

  initial begin
    test_reset();
    test_constant();
    test_pattern({16'h0000, 16'hA5C3});
    test_pattern({16'hFFFF, 16'h5A5B});
    test_late();
    test_early();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule